// File: doc/BRIEF.md
# Zig-Zag Run-Length Coefficient Encoder

This block turns one 8x8 block of quantized transform coefficients into a stream of (last, run, level) symbols for a later variable-length coder. A producer first writes the 64 coefficients into an internal buffer in raster order, addressing each word by its row-major position. A one-cycle start pulse then scans the buffer in zig-zag order, from the low-frequency corner to the high-frequency corner.

A symbol is emitted only for a nonzero coefficient. It carries the count of zeros that came just before that coefficient in scan order, the signed coefficient value, and a flag that is set only on the final nonzero coefficient of the block. Zeros after that coefficient are never sent. Because the flag is only known once the rest of the scan has been seen, each symbol is held back until the next nonzero coefficient turns up or the scan runs out. Symbols leave through a valid/ready handshake, and the scan waits whenever the consumer holds off. A one-cycle done pulse marks the end of each block. An empty flag beside that pulse reports a block with no nonzero coefficient.

Top module: `zz_rle_encoder`

## Requirements
- R1: A coefficient word is stored at raster position `wrAddr` (row*8+column) when `wrEn` is high, but only while the block is idle. Writes and start pulses issued while a block is being encoded are ignored.
- R2: Coefficients are visited in zig-zag order over anti-diagonals, alternating direction, beginning at raster positions 0, 1, 8, 16, 9, 2, 3, 10 and ending at 63.
- R3: A symbol is produced for each nonzero coefficient and for no zero coefficient. `symLevel` equals the coefficient as a 12-bit two's complement value.
- R4: `symRun` (6 bits, 0 to 63) equals the number of zero coefficients between the previous nonzero coefficient, or the start of the scan, and this one.
- R5: `symLast` is 1 on the symbol for the final nonzero coefficient of the block and 0 on every other symbol. No symbol follows it within the block.
- R6: After the last symbol of a block has been accepted, `blockDone` pulses for one cycle. `blockEmpty` is 1 in that cycle exactly when the block held no nonzero coefficient, in which case no symbol is emitted at all.
- R7: While `symValid` is high and `symReady` is low, `symValid`, `symRun`, `symLevel` and `symLast` hold their values. Every symbol is transferred exactly once, whatever the pattern of `symReady`.
- R8: A synchronous active-high `rst` clears the pending symbol, the scan position and the output, leaving `symValid` and `blockDone` low and the block idle.
- R9: Coefficient storage is not cleared by a scan, so a second start without new writes encodes the same block again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Coefficient write strobe |
| wrAddr | input | 6 | Raster position of the written coefficient |
| wrData | input | 12 | Coefficient value, two's complement |
| start | input | 1 | Begins the scan of the stored block |
| symReady | input | 1 | Consumer accepts the current symbol |
| symValid | output | 1 | A symbol is presented |
| symLast | output | 1 | Symbol is for the final nonzero coefficient |
| symRun | output | 6 | Zeros preceding the coefficient in scan order |
| symLevel | output | 12 | Signed coefficient value |
| blockDone | output | 1 | One-cycle end-of-block pulse |
| blockEmpty | output | 1 | Block had no nonzero coefficient, valid with blockDone |

## Verification
The encoder is driven with an all-zero block, which exercises the empty report, and with a lone DC term and a lone final-position term, which give the smallest and largest runs. A fully dense block, with a run of zero before every symbol, and blocks holding the extreme values 2047 and -2048 test sign handling. Sparse pseudo-random blocks of varying density are each paired with an always-ready, an alternating and a random consumer, so stall handling is separated from the scan order. Writes and start pulses are also injected during a scan, followed by a rescan without reloading, which shows the busy guard and the retained buffer.

// File: rtl/zz_rle_pkg.sv
package zz_rle_pkg;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic scanClr;   // restart scan: position, run, pending, seen flag
    logic scanAdv;   // move to next zig-zag position
    logic runInc;    // count one more zero
    logic runClr;    // restart the zero count
    logic pendLoad;  // capture current coefficient as pending symbol
    logic pendClr;   // drop the pending symbol after flushing it
    logic outPush;   // move pending symbol into the output register
    logic outLast;   // last flag for the pushed symbol
  } ctlStrobe_t;

  // Raster index of the k-th coefficient in zig-zag order for a dim x dim block
  function automatic int zz_raster(input int k, input int dim);
    int idx;
    int res;
    int lo;
    int hi;
    int r;
    idx = 0;
    res = 0;
    for (int s = 0; s < 2 * dim - 1; s++) begin
      lo = (s < dim) ? 0 : s - dim + 1;
      hi = (s < dim) ? s : dim - 1;
      for (int i = 0; i <= hi - lo; i++) begin
        r = ((s % 2) == 0) ? hi - i : lo + i;
        if (idx == k) res = r * dim + (s - r);
        idx++;
      end
    end
    return res;
  endfunction

endpackage

// File: rtl/zz_rle_datapath.sv
module zz_rle_datapath
  import zz_rle_pkg::*;
#(
  parameter int COEF_W = 12,
  parameter int DIM    = 8,
  localparam int N     = DIM * DIM,
  localparam int POS_W = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst,
  input  ctlStrobe_t        ctl,
  input  logic              loadOk,
  input  logic              wrEn,
  input  logic [POS_W-1:0]  wrAddr,
  input  logic [COEF_W-1:0] wrData,
  input  logic              symReady,
  output logic              coefNz,
  output logic              atEnd,
  output logic              pendValid,
  output logic              outFree,
  output logic              outValid,
  output logic              anyNz,
  output logic              symLast,
  output logic [POS_W-1:0]  symRun,
  output logic [COEF_W-1:0] symLevel
);

  logic [COEF_W-1:0] coefMem [N];
  logic [POS_W-1:0]  zzMap   [N];
  logic [POS_W-1:0]  scanPos;
  logic [POS_W-1:0]  runCnt;
  logic [POS_W-1:0]  pendRun;
  logic [COEF_W-1:0] pendLevel;
  logic [COEF_W-1:0] curCoef;

  // Zig-zag lookup computed at elaboration
  for (genvar k = 0; k < N; k++) begin : g_zz
    assign zzMap[k] = POS_W'(zz_raster(k, DIM));
  end

  // Coefficient buffer, raster addressed, writable only while idle
  always_ff @(posedge clk) begin
    if (wrEn && loadOk) coefMem[wrAddr] <= wrData;
  end

  assign curCoef = coefMem[zzMap[scanPos]];
  assign coefNz  = (curCoef != '0);
  assign atEnd   = (scanPos == POS_W'(N - 1));

  // Scan position and zero-run counter
  always_ff @(posedge clk) begin
    if (rst || ctl.scanClr) begin
      scanPos <= '0;
      runCnt  <= '0;
    end else begin
      if (ctl.scanAdv) scanPos <= scanPos + 1'b1;
      if (ctl.runClr)      runCnt <= '0;
      else if (ctl.runInc) runCnt <= runCnt + 1'b1;
    end
  end

  // Pending symbol held until its last flag is known
  always_ff @(posedge clk) begin
    if (rst || ctl.scanClr) begin
      pendValid <= 1'b0;
      pendRun   <= '0;
      pendLevel <= '0;
      anyNz     <= 1'b0;
    end else if (ctl.pendLoad) begin
      pendValid <= 1'b1;
      pendRun   <= runCnt;
      pendLevel <= curCoef;
      anyNz     <= 1'b1;
    end else if (ctl.pendClr) begin
      pendValid <= 1'b0;
    end
  end

  // Output register with valid/ready handshake
  assign outFree = !outValid || symReady;

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      symLast  <= 1'b0;
      symRun   <= '0;
      symLevel <= '0;
    end else if (ctl.outPush) begin
      outValid <= 1'b1;
      symLast  <= ctl.outLast;
      symRun   <= pendRun;
      symLevel <= pendLevel;
    end else if (symReady) begin
      outValid <= 1'b0;
    end
  end

  // A stalled symbol holds its fields
  assert_hold_stalled_R7: assert property (@(posedge clk) disable iff (rst)
    (outValid && !symReady) |=> (outValid && $stable(symRun) && $stable(symLevel) && $stable(symLast)));

  // The scan does not move past a nonzero coefficient it cannot hand over
  assert_stall_scan_R7: assert property (@(posedge clk) disable iff (rst)
    (pendValid && coefNz && !outFree && !ctl.scanClr) |=> $stable(scanPos));

  // A captured run never exceeds the positions scanned so far
  assert_run_bound_R4: assert property (@(posedge clk) disable iff (rst)
    ctl.pendLoad |-> (runCnt <= scanPos));

  // Only nonzero levels reach the output
  assert_level_nonzero_R3: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (symLevel != '0));

  // Nothing follows an accepted last symbol
  assert_last_ends_R5: assert property (@(posedge clk) disable iff (rst)
    (outValid && symReady && symLast) |=> !outValid);

endmodule

// File: rtl/zz_rle_control.sv
module zz_rle_control
  import zz_rle_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       coefNz,
  input  logic       atEnd,
  input  logic       pendValid,
  input  logic       outFree,
  input  logic       outValid,
  input  logic       anyNz,
  output ctlStrobe_t ctl,
  output logic       loadOk,
  output logic       blockDone,
  output logic       blockEmpty
);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SCAN,
    ST_FLUSH,
    ST_DRAIN,
    ST_DONE
  } state_t;

  state_t state;
  state_t stateNext;

  always_comb begin
    ctl       = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          ctl.scanClr = 1'b1;
          stateNext   = ST_SCAN;
        end
      end
      ST_SCAN: begin
        if (coefNz) begin
          if (!(pendValid && !outFree)) begin
            ctl.outPush  = pendValid;
            ctl.pendLoad = 1'b1;
            ctl.runClr   = 1'b1;
            ctl.scanAdv  = 1'b1;
          end
        end else begin
          ctl.runInc  = 1'b1;
          ctl.scanAdv = 1'b1;
        end
        if (ctl.scanAdv && atEnd) stateNext = ST_FLUSH;
      end
      ST_FLUSH: begin
        if (!pendValid) begin
          stateNext = ST_DRAIN;
        end else if (outFree) begin
          ctl.outPush = 1'b1;
          ctl.outLast = 1'b1;
          ctl.pendClr = 1'b1;
          stateNext   = ST_DRAIN;
        end
      end
      ST_DRAIN: begin
        if (!outValid) stateNext = ST_DONE;
      end
      ST_DONE: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

  assign loadOk     = (state == ST_IDLE);
  assign blockDone  = (state == ST_DONE);
  assign blockEmpty = (state == ST_DONE) && !anyNz;

  // Done is reported only once the output has drained
  assert_drained_at_done_R6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DONE) |-> !outValid);

  // Nothing is pending once the block is reported done
  assert_no_pending_at_done_R6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DONE) |-> !pendValid);

endmodule

// File: rtl/zz_rle_encoder.sv
module zz_rle_encoder
  import zz_rle_pkg::*;
#(
  parameter int COEF_W = 12,
  parameter int DIM    = 8,
  localparam int POS_W = $clog2(DIM * DIM)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [POS_W-1:0]  wrAddr,
  input  logic [COEF_W-1:0] wrData,
  input  logic              start,
  input  logic              symReady,
  output logic              symValid,
  output logic              symLast,
  output logic [POS_W-1:0]  symRun,
  output logic [COEF_W-1:0] symLevel,
  output logic              blockDone,
  output logic              blockEmpty
);

  ctlStrobe_t ctl;
  logic loadOk;
  logic coefNz;
  logic atEnd;
  logic pendValid;
  logic outFree;
  logic anyNz;

  zz_rle_control i_control (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .coefNz     (coefNz),
    .atEnd      (atEnd),
    .pendValid  (pendValid),
    .outFree    (outFree),
    .outValid   (symValid),
    .anyNz      (anyNz),
    .ctl        (ctl),
    .loadOk     (loadOk),
    .blockDone  (blockDone),
    .blockEmpty (blockEmpty)
  );

  zz_rle_datapath #(
    .COEF_W (COEF_W),
    .DIM    (DIM)
  ) i_datapath (
    .clk       (clk),
    .rst       (rst),
    .ctl       (ctl),
    .loadOk    (loadOk),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .symReady  (symReady),
    .coefNz    (coefNz),
    .atEnd     (atEnd),
    .pendValid (pendValid),
    .outFree   (outFree),
    .outValid  (symValid),
    .anyNz     (anyNz),
    .symLast   (symLast),
    .symRun    (symRun),
    .symLevel  (symLevel)
  );

endmodule

// File: tb/test_zz_rle_encoder.sv
module test_zz_rle_encoder;

  localparam int CLK_PERIOD = 10;
  localparam int N = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0;
  logic [5:0]  wrAddr = '0;
  logic [11:0] wrData = '0;
  logic        start = 1'b0;
  logic        symReady = 1'b0;
  logic        symValid;
  logic        symLast;
  logic [5:0]  symRun;
  logic [11:0] symLevel;
  logic        blockDone;
  logic        blockEmpty;

  int checks = 0;
  int fails  = 0;
  int seed   = 32'h1234_5678;

  int blk   [N];
  int order [N];
  int exRun [N];
  int exLev [N];
  int exLast[N];
  int exCnt;

  always #(CLK_PERIOD / 2) clk = ~clk;

  zz_rle_encoder i_zz_rle_encoder (
    .clk        (clk),
    .rst        (rst),
    .wrEn       (wrEn),
    .wrAddr     (wrAddr),
    .wrData     (wrData),
    .start      (start),
    .symReady   (symReady),
    .symValid   (symValid),
    .symLast    (symLast),
    .symRun     (symRun),
    .symLevel   (symLevel),
    .blockDone  (blockDone),
    .blockEmpty (blockEmpty)
  );

  function automatic int nextRand();
    seed = seed * 1103515245 + 12345;
    return (seed >>> 8) & 32'h7fff;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Zig-zag order by walking the grid, bouncing off the edges
  task automatic buildOrder();
    int r = 0;
    int c = 0;
    for (int k = 0; k < N; k++) begin
      order[k] = r * 8 + c;
      if (((r + c) % 2) == 0) begin
        if (c == 7) r++;
        else if (r == 0) c++;
        else begin r--; c++; end
      end else begin
        if (r == 7) c++;
        else if (c == 0) r++;
        else begin r++; c--; end
      end
    end
  endtask

  task automatic buildExpect();
    int zeros = 0;
    exCnt = 0;
    for (int k = 0; k < N; k++) begin
      if (blk[order[k]] != 0) begin
        exRun[exCnt]  = zeros;
        exLev[exCnt]  = blk[order[k]];
        exLast[exCnt] = 0;
        exCnt++;
        zeros = 0;
      end else begin
        zeros++;
      end
    end
    if (exCnt > 0) exLast[exCnt-1] = 1;
  endtask

  task automatic loadBlock();
    for (int a = 0; a < N; a++) begin
      @(negedge clk);
      wrEn   = 1'b1;
      wrAddr = 6'(a);
      wrData = 12'(blk[a]);
    end
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // readyMode: 0 always, 1 alternating, 2 random; meddle: writes/start while busy
  task automatic runBlock(input int readyMode, input bit meddle);
    int got = 0;
    int cyc = 0;
    bit prevStall = 1'b0;
    int hRun = 0;
    int hLev = 0;
    int hLast = 0;
    bit done = 1'b0;
    buildExpect();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && cyc < 2000) begin
      if (prevStall) begin
        check(symValid == 1'b1, "R7 valid held", int'(symValid), 1);
        check(int'(symRun) == hRun && int'($signed(symLevel)) == hLev && int'(symLast) == hLast,
              "R7 fields held", int'($signed(symLevel)), hLev);
      end
      case (readyMode)
        0: symReady = 1'b1;
        1: symReady = cyc[0];
        default: symReady = (nextRand() % 3) != 0;
      endcase
      if (meddle) begin
        wrEn   = 1'b1;
        wrAddr = 6'(cyc);
        wrData = 12'h005;
        start  = cyc[1];
      end
      if (blockDone) begin
        done = 1'b1;
        check(int'(blockEmpty) == (exCnt == 0 ? 1 : 0), "R6 empty flag", int'(blockEmpty), exCnt == 0 ? 1 : 0);
        check(got == exCnt, "R3 symbol count", got, exCnt);
      end else if (symValid && symReady) begin
        if (got < exCnt) begin
          check(int'($signed(symLevel)) == exLev[got], "R2 R3 level in order", int'($signed(symLevel)), exLev[got]);
          check(int'(symRun) == exRun[got], "R4 run", int'(symRun), exRun[got]);
          check(int'(symLast) == exLast[got], "R5 last flag", int'(symLast), exLast[got]);
        end else begin
          check(1'b0, "R5 extra symbol", got, exCnt);
        end
        got++;
      end
      prevStall = symValid && !symReady;
      hRun  = int'(symRun);
      hLev  = int'($signed(symLevel));
      hLast = int'(symLast);
      @(negedge clk);
      cyc++;
    end
    wrEn = 1'b0;
    start = 1'b0;
    symReady = 1'b0;
    check(done, "R6 done pulse", int'(done), 1);
    @(negedge clk);
    check(blockDone == 1'b0, "R6 done one cycle", int'(blockDone), 0);
  endtask

  task automatic clearBlk();
    for (int a = 0; a < N; a++) blk[a] = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    buildOrder();
    repeat (3) @(negedge clk);
    check(symValid == 1'b0, "R8 reset valid", int'(symValid), 0);
    check(blockDone == 1'b0, "R8 reset done", int'(blockDone), 0);
    rst = 1'b0;
    @(negedge clk);
    check(symValid == 1'b0 && blockDone == 1'b0, "R8 idle after reset", int'(symValid), 0);

    // All zero: empty block (R6)
    clearBlk();
    loadBlock();
    runBlock(0, 1'b0);

    // Lone DC term (R4 run 0, R5 last)
    clearBlk();
    blk[0] = 5;
    loadBlock();
    runBlock(0, 1'b0);

    // Lone final-position term, run 63 (R4)
    clearBlk();
    blk[63] = -7;
    loadBlock();
    runBlock(1, 1'b0);

    // Dense block of alternating signs (R2, R3)
    for (int a = 0; a < N; a++) blk[a] = (a % 2 == 0) ? a + 1 : -(a + 1);
    loadBlock();
    runBlock(0, 1'b0);
    runBlock(2, 1'b0);

    // Extreme values (R3)
    clearBlk();
    blk[1] = 2047; blk[8] = -2048; blk[36] = -1; blk[62] = 2047;
    loadBlock();
    runBlock(1, 1'b0);

    // Writes and start during scan ignored, then rescan unchanged (R1, R9)
    runBlock(2, 1'b1);
    runBlock(0, 1'b0);

    // Sparse pseudo-random blocks under each ready pattern
    for (int t = 0; t < 18; t++) begin
      for (int a = 0; a < N; a++) begin
        int v;
        v = nextRand();
        if ((v % 8) < (t % 6) + 1) blk[a] = (nextRand() % 4095) - 2047;
        else blk[a] = 0;
      end
      loadBlock();
      runBlock(t % 3, 1'b0);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule